// File: doc/BRIEF.md
# Serial Flash Clock Divider And Gates

This block derives the two clocks a serial-flash controller runs on from one fast parent clock. A source stage divides the parent by 5 or 6. A selectable even divider of 2, 4, 6 or 8 follows it and produces the main flash clock. A further fixed halving of the main clock gives a half-rate clock. All choices sit in one 10-bit control register. Software changes one field by reading the register, editing that field and writing the whole word back.

Each output has its own gate, and a set bit in the register stops that output. A gate opens or closes only while its ungated clock is low, so no output ever shows a shortened high pulse. A new divider setting is not applied at once. It is loaded when the current main-clock period ends, so every period has the length of one complete setting. Reserved codes in a write are dropped field by field. The other fields of that write still land.

Top module: `sflash_clkgen`

## Requirements
- R1: After reset the register reads 0x311: both gate-off bits set, source code 2 and main code 1. Both outputs stay low.
- R2: Register bits 4:3 choose the source division. Code 2 divides the parent by 5 and code 3 divides it by 6. The flash clock period in parent cycles is the source division times the main division.
- R3: Register bits 2:0 choose the main division. Codes 1, 3, 5 and 7 divide by 2, 4, 6 and 8. The flash clock is high for exactly half of each period.
- R4: The half-rate clock has twice the flash period and a 50% duty cycle. It rises together with every second rising edge of the flash clock.
- R5: While bit 8 is set, the flash clock output stays low. While it is clear, the flash clock runs.
- R6: While bit 9 is set, the half-rate output stays low. While it is clear, the half-rate clock runs.
- R7: A gate changes state only while its ungated clock is low. Every high pulse on an output therefore has full length, whenever the gate bit is written.
- R8: A write with source code 0 or 1 leaves the source field unchanged. A write with an even main code leaves the main field unchanged. The other fields of the same write still take effect.
- R9: Divider settings are loaded in the last parent cycle of a flash period. A write that lands in that same cycle first affects the period after the next one.
- R10: The register reads back every field as stored. Bits 7:5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe for the control register |
| regWdata | input | 10 | Write data, a whole register word |
| regRdata | output | 10 | Current register contents |
| flashClk | output | 1 | Gated main flash clock |
| halfClk | output | 1 | Gated half-rate clock |

## Verification
A register write and the loading of divider settings at a period end can fall in the same parent cycle. The bench finds the cycle where the flash clock rises and counts forward to the last cycle of that period. It times a divider write to land exactly at that edge. It then checks that the next period still has the old length and the one after it has the new length. A second write, placed one cycle earlier, must change the very next period. This shows the boundary falls between those two cycles.

// File: rtl/sflash_clkgen_pkg.sv
package sflash_clkgen_pkg;
  localparam int RegW        = 10;
  localparam int MainLsb     = 0;
  localparam int MainW       = 3;
  localparam int SrcLsb      = 3;
  localparam int SrcW        = 2;
  localparam int FlashOffBit = 8;
  localparam int HalfOffBit  = 9;
  localparam int SrcBaseDiv  = 5;
  localparam int MaxMainDiv  = 1 << MainW;
  localparam int MaxSrcDiv   = SrcBaseDiv + 1;
  localparam int CntW        = $clog2((MaxMainDiv > MaxSrcDiv ? MaxMainDiv : MaxSrcDiv) + 1);
  localparam logic [RegW-1:0] RegReset = RegW'(10'h311);

  typedef struct packed {
    logic [SrcW-1:0]  srcCode;
    logic [MainW-1:0] mainCode;
    logic             flashOn;
    logic             halfOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/sflash_clk_ctrl.sv
module sflash_clk_ctrl
  import sflash_clkgen_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [RegW-1:0] regWdata,
  input  logic            rawFlash,
  input  logic            rawHalf,
  output logic [RegW-1:0] regRdata,
  output ctrlStrobe_t     strb
);
  logic [SrcW-1:0]  srcSel;
  logic [MainW-1:0] mainSel;
  logic             flashOff, halfOff;
  logic             flashOn, halfOn;
  logic             srcLegal, mainLegal;

  // source codes with the upper bit set are legal, odd main codes are legal
  assign srcLegal  = regWdata[SrcLsb + SrcW - 1];
  assign mainLegal = regWdata[MainLsb];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel   <= RegReset[SrcLsb +: SrcW];
      mainSel  <= RegReset[MainLsb +: MainW];
      flashOff <= RegReset[FlashOffBit];
      halfOff  <= RegReset[HalfOffBit];
    end else if (regWe) begin
      flashOff <= regWdata[FlashOffBit];
      halfOff  <= regWdata[HalfOffBit];
      if (srcLegal)  srcSel  <= regWdata[SrcLsb +: SrcW];
      if (mainLegal) mainSel <= regWdata[MainLsb +: MainW];
    end
  end

  // gates follow their control bits only while the ungated clock is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashOn <= 1'b0;
      halfOn  <= 1'b0;
    end else begin
      if (!rawFlash) flashOn <= !flashOff;
      if (!rawHalf)  halfOn  <= !halfOff;
    end
  end

  always_comb begin
    regRdata                        = '0;
    regRdata[SrcLsb +: SrcW]        = srcSel;
    regRdata[MainLsb +: MainW]      = mainSel;
    regRdata[FlashOffBit]           = flashOff;
    regRdata[HalfOffBit]            = halfOff;
    strb.srcCode                    = srcSel;
    strb.mainCode                   = mainSel;
    strb.flashOn                    = flashOn;
    strb.halfOn                     = halfOn;
  end

  // R8
  src_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regWdata[SrcLsb + SrcW - 1]) |=> $stable(srcSel));
  // R8
  main_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regWdata[MainLsb]) |=> $stable(mainSel));
  // R7
  flash_gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flashOn) |-> !$past(rawFlash));
  // R7
  half_gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(halfOn) |-> !$past(rawHalf));
endmodule

// File: rtl/sflash_clk_dpath.sv
module sflash_clk_dpath
  import sflash_clkgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  output logic        rawFlash,
  output logic        rawHalf,
  output logic        flashClk,
  output logic        halfClk
);
  logic [CntW-1:0] srcLim, mainLim, srcCnt, mainCnt;
  logic            srcTick, lastMain, periodEnd;
  logic            halfTgl;

  assign srcTick   = (srcCnt == srcLim - CntW'(1));
  assign lastMain  = (mainCnt == mainLim - CntW'(1));
  assign periodEnd = srcTick && lastMain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcCnt  <= '0;
      mainCnt <= '0;
      srcLim  <= CntW'(SrcBaseDiv);
      mainLim <= CntW'(RegReset[MainLsb +: MainW]) + CntW'(1);
      halfTgl <= 1'b0;
    end else begin
      srcCnt <= srcTick ? '0 : srcCnt + CntW'(1);
      if (srcTick) mainCnt <= lastMain ? '0 : mainCnt + CntW'(1);
      if (periodEnd) begin
        srcLim  <= CntW'(SrcBaseDiv) + CntW'(strb.srcCode[0]);
        mainLim <= CntW'(strb.mainCode) + CntW'(1);
        halfTgl <= ~halfTgl;
      end
    end
  end

  assign rawFlash = (mainCnt < (mainLim >> 1));
  assign rawHalf  = halfTgl;
  assign flashClk = rawFlash && strb.flashOn;
  assign halfClk  = rawHalf && strb.halfOn;

  // R2
  src_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcCnt < srcLim);
  // R9
  load_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mainLim) || !$stable(srcLim)) |-> $past(periodEnd));
  // R4
  half_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawHalf) |-> $rose(rawFlash));
  // R3
  main_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt < mainLim);
endmodule

// File: rtl/sflash_clkgen.sv
module sflash_clkgen
  import sflash_clkgen_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [RegW-1:0] regWdata,
  output logic [RegW-1:0] regRdata,
  output logic            flashClk,
  output logic            halfClk
);
  ctrlStrobe_t strb;
  logic        rawFlash, rawHalf;

  sflash_clk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .rawFlash(rawFlash), .rawHalf(rawHalf), .regRdata(regRdata), .strb(strb)
  );

  sflash_clk_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rawFlash(rawFlash),
    .rawHalf(rawHalf), .flashClk(flashClk), .halfClk(halfClk)
  );
endmodule

// File: tb/test_sflash_clkgen.sv
`timescale 1ns/1ps
module test_sflash_clkgen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [9:0] regWdata = '0;
  logic [9:0] regRdata;
  logic       flashClk, halfClk;
  int         checks = 0;
  int         errors = 0;

  sflash_clkgen i_sflash_clkgen (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .flashClk(flashClk), .halfClk(halfClk)
  );

  always #2 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sigOf(int which);
    return (which != 0) ? halfClk : flashClk;
  endfunction

  task automatic writeReg(logic [9:0] d);
    regWe = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rmw(logic [9:0] clr, logic [9:0] set);
    writeReg((regRdata & ~clr) | set);
  endtask

  task automatic waitRise(int which);
    logic prev;
    do begin
      prev = sigOf(which);
      @(negedge clk);
    end while (!(sigOf(which) && !prev));
  endtask

  // called at the negedge where the signal has just risen
  task automatic countFrom(int which, output int hi, output int per);
    logic prev;
    hi = 0;
    per = 0;
    do begin
      if (sigOf(which)) hi++;
      per++;
      prev = sigOf(which);
      @(negedge clk);
    end while (!(sigOf(which) && !prev));
  endtask

  task automatic measure(int which, output int hi, output int per);
    waitRise(which);
    countFrom(which, hi, per);
  endtask

  task automatic countHigh(int which, int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      if (sigOf(which)) hi++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    int hiF, hiH;
    check("R1 reset register", int'(regRdata), 'h311);
    countHigh(0, 40, hiF);
    countHigh(1, 40, hiH);
    check("R1 R5 flash low after reset", hiF, 0);
    check("R1 R6 half low after reset", hiH, 0);
  endtask

  task automatic testReadback();
    writeReg(10'h3F9);
    check("R10 readback with bits 7:5 zero", int'(regRdata), 'h319);
  endtask

  task automatic testEnable();
    int hi, per;
    writeReg(10'h011);
    measure(0, hi, per);
    measure(0, hi, per);
    check("R2 R3 flash period div5x2", per, 10);
    check("R3 flash high half", hi, 5);
    measure(1, hi, per);
    measure(1, hi, per);
    check("R4 half period", per, 20);
    check("R4 half duty", hi, 10);
  endtask

  task automatic testSweep();
    int hi, per;
    for (int s = 2; s <= 3; s++) begin
      for (int m = 1; m <= 7; m += 2) begin
        writeReg(10'((s << 3) | m));
        measure(0, hi, per);
        measure(0, hi, per);
        check("R2 R3 sweep period", per, (3 + s) * (m + 1));
        check("R3 sweep high time", hi, ((3 + s) * (m + 1)) / 2);
      end
    end
    measure(1, hi, per);
    check("R4 half period at div6x8", per, 96);
  endtask

  task automatic testReserved();
    int hi, per;
    writeReg(10'h20C);
    check("R8 reserved codes kept, gate bits written", int'(regRdata), 'h21F);
    measure(0, hi, per);
    measure(0, hi, per);
    check("R8 flash period unchanged", per, 48);
    countHigh(1, 100, hi);
    countHigh(1, 200, hi);
    check("R6 half gated off", hi, 0);
  endtask

  task automatic testGate();
    int hi, per;
    writeReg(10'h011);
    measure(0, hi, per);
    measure(0, hi, per);
    waitRise(0);
    hi = 1;
    rmw(10'h000, 10'h100);
    while (flashClk) begin
      hi++;
      @(negedge clk);
    end
    check("R7 pulse full after mid-high disable", hi, 5);
    countHigh(0, 40, hi);
    check("R5 flash gated off", hi, 0);
    repeat (3) @(negedge clk);
    rmw(10'h100, 10'h000);
    measure(0, hi, per);
    check("R7 first pulse after enable full", hi, 5);
    check("R5 flash runs again", per, 10);
  endtask

  task automatic testBoundary();
    int hi, per;
    writeReg(10'h011);
    measure(0, hi, per);
    measure(0, hi, per);
    waitRise(0);
    repeat (9) @(negedge clk);
    writeReg(10'h013);
    countFrom(0, hi, per);
    check("R9 write at period end keeps next period", per, 10);
    countFrom(0, hi, per);
    check("R9 setting applies one period later", per, 20);
    repeat (18) @(negedge clk);
    writeReg(10'h011);
    measure(0, hi, per);
    check("R9 write one cycle earlier applies next period", per, 10);
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testEnable();
    testSweep();
    testReserved();
    testGate();
    testBoundary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule